// File: doc/BRIEF.md
# Thermal Sensor Scan Supervisor

This block supervises up to four on-die temperature sensors through one shared converter. On its own it starts a conversion on each enabled channel in turn and keeps the most recent code of each channel. It compares every code with a per-channel trip level. A trip that persists for a programmed number of samples raises an interrupt or a latched shutdown. Between sweeps the block waits a programmable interval. The interval is long while everything is cool and short once any channel reads past its trip level. Sweeps therefore speed up when the die is hot.

Software programs the block through a small 32-bit register port with write strobes and combinational reads. The converter sits outside the block. The block asks for a conversion on a selected channel and receives the code together with a one-cycle done pulse. A latched shutdown drives a general-purpose pin with programmable polarity, a chip-reset request, or both, selected per channel.

Top module: `thermal_monitor`

## Requirements
- R1: After reset every register reads zero, irq and shut_rst are low, adc_start is low, and shut_gpio is high (the inactive level of the default active-low polarity).
- R2: While scanning is on (control bit 0), a sweep requests channels in ascending index order. It visits only channels whose control bit 4+c is set. It holds adc_start high and adc_chan steady until adc_done arrives, and it spends one cycle passing each disabled index.
- R3: The code accepted with adc_done is stored for that channel and reads back, zero-extended, at 0x20+4c.
- R4: A sweep ends after the last index. The next request on the first enabled channel then comes after (indexes above the last enabled one) + P·PRESC_DIV + (index of the first enabled channel) cycles with adc_start low. P is the high-temperature period (0x6C) if any channel's latest sample was past its level, else the normal period (0x68). A period of 0 counts as 1.
- R5: A sample is past its level when code ≤ the channel's level at 0x40+4c. A code one above the level is not past.
- R6: Each channel keeps an interrupt count (limit at 0x60) and a shutdown count (limit at 0x64). A sample that is not past clears both counts. A past sample raises each count by one, stopping at its limit. Pending bit c (0x0C bit c) is set on a past sample whose new interrupt count equals or exceeds its limit. irq is the OR of pending bit c AND enable bit c (0x08 bit c).
- R7: Writing 1 to pending bit c clears it, but a set in the same cycle wins. Bit 8 of 0x0C reads 1 once any channel has latched a shutdown, and no bus write clears it.
- R8: A past sample whose new shutdown count equals or exceeds its limit latches channel c's shutdown until reset. With scanning on, shut_rst is high if a latched channel has 0x08 bit 8+c set. The shutdown pin is in its active state if a latched channel has 0x08 bit 4+c set.
- R9: Control bit 8 selects the active level of shut_gpio: 1 makes it active-high, 0 active-low. The pin otherwise sits at the opposite level.
- R10: With scanning off, adc_start stays low, shut_rst is low, and shut_gpio is at its inactive level. An open request is dropped, and the next sweep starts again from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| adc_start | output | 1 | Conversion request, held until adc_done |
| adc_chan | output | 2 | Channel being converted |
| adc_done | input | 1 | One-cycle pulse: adc_code is valid |
| adc_code | input | 12 | Converted sample |
| irq | output | 1 | Interrupt request, active-high |
| shut_gpio | output | 1 | Shutdown pin, programmable polarity |
| shut_rst | output | 1 | Chip-reset request, active-high |

## Verification
The converter model returns a steady cool code, a code exactly at the trip level, a code one count above it, and a code that alternates hot and cold on every sample. These four patterns separate the ≤ comparison from a strict one and show that a broken streak restarts the count. Steady hot readings must reach both limits, so they separate the interrupt limit from the shutdown limit. The gap counter sees cool sweeps, hot sweeps, a zero period, and a channel set whose first index is disabled, so it checks the choice of period and the skip cycles. Clears, polarity flips and disabling scanning are each issued while a trip is latched.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   localparam int MAX_CH = 4;
   localparam int CH_W   = 2;
   localparam int ADDR_W = 8;
   localparam int BUS_W  = 32;

   localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h20;
   localparam logic [ADDR_W-1:0] OFS_LVL   = 8'h40;
   localparam logic [ADDR_W-1:0] OFS_IDEB  = 8'h60;
   localparam logic [ADDR_W-1:0] OFS_SDEB  = 8'h64;
   localparam logic [ADDR_W-1:0] OFS_PCOOL = 8'h68;
   localparam logic [ADDR_W-1:0] OFS_PHOT  = 8'h6C;

   localparam int B_RUN  = 0;
   localparam int B_SRC  = 4;
   localparam int B_POL  = 8;
   localparam int B_IEN  = 0;
   localparam int B_GPIO = 4;
   localparam int B_RST  = 8;
   localparam int B_STAT = 8;

   typedef enum logic {SEQ_WAIT, SEQ_SCAN} seq_state_t;
endpackage

// File: rtl/tmon_regs.sv
module tmon_regs import tmon_pkg::*; #(
   parameter int N_CH   = 4,
   parameter int CODE_W = 12,
   parameter int DEB_W  = 8,
   parameter int PER_W  = 16
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wen,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [BUS_W-1:0]             bus_wdata,
   output logic [BUS_W-1:0]             bus_rdata,
   input  logic [N_CH-1:0][CODE_W-1:0]  ch_data,
   input  logic [N_CH-1:0]              ch_pend,
   input  logic [N_CH-1:0]              ch_shut,
   output logic                         run,
   output logic                         pol_hi,
   output logic [N_CH-1:0]              src_en,
   output logic [N_CH-1:0]              irq_en,
   output logic [N_CH-1:0]              to_gpio,
   output logic [N_CH-1:0]              to_rst,
   output logic [N_CH-1:0][CODE_W-1:0]  lvl,
   output logic [DEB_W-1:0]             int_lim,
   output logic [DEB_W-1:0]             shut_lim,
   output logic [PER_W-1:0]             per_cool,
   output logic [PER_W-1:0]             per_hot,
   output logic [N_CH-1:0]              pend_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         pol_hi   <= 1'b0;
         src_en   <= '0;
         irq_en   <= '0;
         to_gpio  <= '0;
         to_rst   <= '0;
         lvl      <= '0;
         int_lim  <= '0;
         shut_lim <= '0;
         per_cool <= '0;
         per_hot  <= '0;
      end else if (bus_wen) begin
         if (bus_addr == OFS_CTL) begin
            run    <= bus_wdata[B_RUN];
            src_en <= bus_wdata[B_SRC +: N_CH];
            pol_hi <= bus_wdata[B_POL];
         end
         if (bus_addr == OFS_ROUTE) begin
            irq_en  <= bus_wdata[B_IEN  +: N_CH];
            to_gpio <= bus_wdata[B_GPIO +: N_CH];
            to_rst  <= bus_wdata[B_RST  +: N_CH];
         end
         if (bus_addr == OFS_IDEB)  int_lim  <= bus_wdata[DEB_W-1:0];
         if (bus_addr == OFS_SDEB)  shut_lim <= bus_wdata[DEB_W-1:0];
         if (bus_addr == OFS_PCOOL) per_cool <= bus_wdata[PER_W-1:0];
         if (bus_addr == OFS_PHOT)  per_hot  <= bus_wdata[PER_W-1:0];
         for (int c = 0; c < N_CH; c++) begin
            if (bus_addr == OFS_LVL + ADDR_W'(4*c)) lvl[c] <= bus_wdata[CODE_W-1:0];
         end
      end
   end

   always_comb begin
      pend_clr = '0;
      if (bus_wen && bus_addr == OFS_PEND) pend_clr = bus_wdata[N_CH-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTL: begin
            bus_rdata[B_RUN]         = run;
            bus_rdata[B_SRC +: N_CH] = src_en;
            bus_rdata[B_POL]         = pol_hi;
         end
         OFS_ROUTE: begin
            bus_rdata[B_IEN  +: N_CH] = irq_en;
            bus_rdata[B_GPIO +: N_CH] = to_gpio;
            bus_rdata[B_RST  +: N_CH] = to_rst;
         end
         OFS_PEND: begin
            bus_rdata[N_CH-1:0] = ch_pend;
            bus_rdata[B_STAT]   = |ch_shut;
         end
         OFS_IDEB:  bus_rdata[DEB_W-1:0] = int_lim;
         OFS_SDEB:  bus_rdata[DEB_W-1:0] = shut_lim;
         OFS_PCOOL: bus_rdata[PER_W-1:0] = per_cool;
         OFS_PHOT:  bus_rdata[PER_W-1:0] = per_hot;
         default: begin
            for (int c = 0; c < N_CH; c++) begin
               if (bus_addr == OFS_DATA + ADDR_W'(4*c)) bus_rdata[CODE_W-1:0] = ch_data[c];
               if (bus_addr == OFS_LVL  + ADDR_W'(4*c)) bus_rdata[CODE_W-1:0] = lvl[c];
            end
         end
      endcase
   end
endmodule

// File: rtl/tmon_seq.sv
module tmon_seq import tmon_pkg::*; #(
   parameter int N_CH      = 4,
   parameter int PER_W     = 16,
   parameter int PRESC_DIV = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [N_CH-1:0]   src_en,
   input  logic [PER_W-1:0]  per_cool,
   input  logic [PER_W-1:0]  per_hot,
   input  logic              hot,
   input  logic              adc_done,
   output logic              adc_start,
   output logic [CH_W-1:0]   adc_chan,
   output logic              accept
);
   localparam int             PS_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
   localparam logic [CH_W-1:0] LAST = CH_W'(N_CH - 1);

   seq_state_t       state;
   logic [CH_W-1:0]  idx;
   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] lim;
   logic [PER_W-1:0] span;
   logic             tick;

   assign lim  = hot ? per_hot : per_cool;
   assign span = (lim == '0) ? PER_W'(1) : lim;

   generate
      if (PRESC_DIV == 1) begin : g_nodiv
         assign tick = run && (state == SEQ_WAIT);
      end else begin : g_div
         logic [PS_W-1:0] ps;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ps <= '0;
            else if (run) begin
               if (state == SEQ_SCAN || ps == PS_W'(PRESC_DIV - 1)) ps <= '0;
               else ps <= ps + PS_W'(1);
            end
         end
         assign tick = run && (state == SEQ_WAIT) && (ps == PS_W'(PRESC_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_WAIT;
         idx   <= '0;
         cnt   <= '0;
      end else if (!run) begin
         state <= SEQ_WAIT;
         idx   <= '0;
      end else begin
         case (state)
            SEQ_WAIT: if (tick) begin
               if (cnt >= span - PER_W'(1)) begin
                  cnt   <= '0;
                  idx   <= '0;
                  state <= SEQ_SCAN;
               end else begin
                  cnt <= cnt + PER_W'(1);
               end
            end
            SEQ_SCAN: if (!src_en[idx] || adc_done) begin
               if (idx == LAST) begin
                  state <= SEQ_WAIT;
                  cnt   <= '0;
               end else begin
                  idx <= idx + CH_W'(1);
               end
            end
            default: state <= SEQ_WAIT;
         endcase
      end
   end

   assign adc_start = run && (state == SEQ_SCAN) && src_en[idx];
   assign adc_chan  = idx;
   assign accept    = adc_start && adc_done;

   AST_TICK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (state == SEQ_WAIT && run)) else $error("tick outside wait"); // R4
endmodule

// File: rtl/tmon_chan.sv
module tmon_chan #(
   parameter int CODE_W = 12,
   parameter int DEB_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] lvl,
   input  logic [DEB_W-1:0]  int_lim,
   input  logic [DEB_W-1:0]  shut_lim,
   input  logic              pend_clr,
   output logic [CODE_W-1:0] data,
   output logic              over,
   output logic              pend,
   output logic              shut
);
   logic             past;
   logic [DEB_W-1:0] icnt, scnt, inxt, snxt;

   assign past = (code <= lvl);
   assign inxt = !past ? '0 : (icnt >= int_lim)  ? int_lim  : icnt + DEB_W'(1);
   assign snxt = !past ? '0 : (scnt >= shut_lim) ? shut_lim : scnt + DEB_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         over <= 1'b0;
         icnt <= '0;
         scnt <= '0;
         pend <= 1'b0;
         shut <= 1'b0;
      end else begin
         if (sample) begin
            data <= code;
            over <= past;
            icnt <= inxt;
            scnt <= snxt;
         end
         pend <= (pend && !pend_clr) || (sample && past && inxt >= int_lim);
         shut <= shut || (sample && past && snxt >= shut_lim);
      end
   end

   AST_STREAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && code > lvl) |=> (icnt == '0 && scnt == '0)) else $error("streak kept"); // R6
   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && code <= lvl) |=> icnt <= $past(int_lim)) else $error("count past limit"); // R6
   AST_SHUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      shut |=> shut) else $error("shutdown dropped"); // R8
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor import tmon_pkg::*; #(
   parameter int N_CH      = 4,
   parameter int CODE_W    = 12,
   parameter int DEB_W     = 8,
   parameter int PER_W     = 16,
   parameter int PRESC_DIV = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              adc_start,
   output logic [CH_W-1:0]   adc_chan,
   input  logic              adc_done,
   input  logic [CODE_W-1:0] adc_code,
   output logic              irq,
   output logic              shut_gpio,
   output logic              shut_rst
);
   generate
      if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_ch
         $error("N_CH must lie in 1..4");
      end
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("PRESC_DIV must be at least 1");
      end
      if (CODE_W > 16 || DEB_W > 16 || PER_W > 16) begin : g_bad_w
         $error("register fields are at most 16 bits");
      end
   endgenerate

   logic                        run, pol_hi, hot, accept;
   logic [N_CH-1:0]             src_en, irq_en, to_gpio, to_rst, pend_clr;
   logic [N_CH-1:0]             ch_pend, ch_shut, ch_over;
   logic [N_CH-1:0][CODE_W-1:0] ch_data, lvl;
   logic [DEB_W-1:0]            int_lim, shut_lim;
   logic [PER_W-1:0]            per_cool, per_hot;

   tmon_regs #(.N_CH(N_CH), .CODE_W(CODE_W), .DEB_W(DEB_W), .PER_W(PER_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_data(ch_data), .ch_pend(ch_pend), .ch_shut(ch_shut),
      .run(run), .pol_hi(pol_hi), .src_en(src_en), .irq_en(irq_en),
      .to_gpio(to_gpio), .to_rst(to_rst), .lvl(lvl), .int_lim(int_lim),
      .shut_lim(shut_lim), .per_cool(per_cool), .per_hot(per_hot), .pend_clr(pend_clr)
   );

   tmon_seq #(.N_CH(N_CH), .PER_W(PER_W), .PRESC_DIV(PRESC_DIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en),
      .per_cool(per_cool), .per_hot(per_hot), .hot(hot), .adc_done(adc_done),
      .adc_start(adc_start), .adc_chan(adc_chan), .accept(accept)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tmon_chan #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .sample(accept && adc_chan == CH_W'(c)),
         .code(adc_code), .lvl(lvl[c]), .int_lim(int_lim), .shut_lim(shut_lim),
         .pend_clr(pend_clr[c]), .data(ch_data[c]), .over(ch_over[c]),
         .pend(ch_pend[c]), .shut(ch_shut[c])
      );
   end

   assign hot       = |ch_over;
   assign irq       = |(ch_pend & irq_en);
   assign shut_rst  = run && |(ch_shut & to_rst);
   assign shut_gpio = (run && |(ch_shut & to_gpio)) ? pol_hi : !pol_hi;

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !adc_start) else $error("request while idle"); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (shut_gpio == !pol_hi && !shut_rst)) else $error("shutdown while idle"); // R10
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_start && !adc_done) |=> (!adc_start || $stable(adc_chan))) else $error("channel moved"); // R2
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |ch_pend) else $error("irq without pending"); // R6
endmodule

// File: tb/tb_thermal_monitor.sv
module tb_thermal_monitor;
   localparam int CLK_P = 10;
   localparam int DIV   = 2;
   localparam int NCH   = 4;
   localparam int LAT   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        adc_start;
   logic [1:0]  adc_chan;
   logic        adc_done = 1'b0;
   logic [11:0] adc_code = '0;
   logic        irq, shut_gpio, shut_rst;

   thermal_monitor #(.N_CH(NCH), .PRESC_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_start(adc_start),
      .adc_chan(adc_chan), .adc_done(adc_done), .adc_code(adc_code),
      .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fin();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // behavioural reference state
   bit       m_run, m_pol;
   bit [3:0] m_src, m_ien, m_gpio, m_rst, m_pend, m_shut, m_over;
   int       m_lvl[NCH], m_data[NCH], m_icnt[NCH], m_scnt[NCH];
   int       m_ideb, m_sdeb, m_pcool, m_phot;

   // converter model
   int       code_tab[NCH];
   bit [3:0] alt, alt_ph;
   int       lat;
   bit       mon_start;
   int       mon_chan;

   // order and gap tracking
   bit order_ok = 1;
   int exp_ch = 0;
   bit gap_arm = 0, gap_valid = 0;
   int gap_cnt = 0, exp_gap = 0;

   function automatic int first_en(input bit [3:0] s);
      for (int i = 0; i < NCH; i++) if (s[i]) return i;
      return 0;
   endfunction

   function automatic int last_en(input bit [3:0] s);
      for (int i = NCH-1; i >= 0; i--) if (s[i]) return i;
      return 0;
   endfunction

   function automatic int next_en(input bit [3:0] s, input int c);
      for (int i = c+1; i < NCH; i++) if (s[i]) return i;
      return first_en(s);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         8'h04: r = {23'b0, m_pol, m_src, 3'b0, m_run};
         8'h08: r = {20'b0, m_rst, m_gpio, m_ien};
         8'h0C: r = {23'b0, |m_shut, 4'b0, m_pend};
         8'h60: r = 32'(m_ideb);
         8'h64: r = 32'(m_sdeb);
         8'h68: r = 32'(m_pcool);
         8'h6C: r = 32'(m_phot);
         default: for (int c = 0; c < NCH; c++) begin
            if (a == 8'(8'h20 + 4*c)) r = 32'(m_data[c]);
            if (a == 8'(8'h40 + 4*c)) r = 32'(m_lvl[c]);
         end
      endcase
      return r;
   endfunction

   // reference update at every rising edge
   always @(posedge clk) begin
      bit [3:0] setp, sets, clr;
      int c, k, p;
      bit past;
      if (!rst_n) begin
         m_run = 0; m_pol = 0; m_src = 0; m_ien = 0; m_gpio = 0; m_rst = 0;
         m_pend = 0; m_shut = 0; m_over = 0;
         m_ideb = 0; m_sdeb = 0; m_pcool = 0; m_phot = 0;
         for (int i = 0; i < NCH; i++) begin
            m_lvl[i] = 0; m_data[i] = 0; m_icnt[i] = 0; m_scnt[i] = 0;
         end
      end else begin
         setp = 0; sets = 0;
         clr = (bus_wen && bus_addr == 8'h0C) ? bus_wdata[3:0] : 4'h0;
         if (mon_start && adc_done) begin
            c = mon_chan; k = int'(adc_code);
            if (order_ok) chk(c == exp_ch, "R2 sweep order", c, exp_ch);
            past = (k <= m_lvl[c]);
            m_data[c] = k;
            m_over[c] = past;
            if (past) begin
               m_icnt[c] = (m_icnt[c] >= m_ideb) ? m_ideb : m_icnt[c] + 1;
               m_scnt[c] = (m_scnt[c] >= m_sdeb) ? m_sdeb : m_scnt[c] + 1;
               if (m_icnt[c] >= m_ideb) setp[c] = 1;
               if (m_scnt[c] >= m_sdeb) sets[c] = 1;
            end else begin
               m_icnt[c] = 0; m_scnt[c] = 0;
            end
            if (c == last_en(m_src)) begin
               p = (|m_over) ? m_phot : m_pcool;
               if (p == 0) p = 1;
               exp_gap = (NCH-1-c) + p*DIV + first_en(m_src);
               gap_arm = 1; gap_cnt = 0; gap_valid = 1;
               order_ok = 1;
               exp_ch = first_en(m_src);
            end else begin
               exp_ch = next_en(m_src, c);
            end
         end
         m_pend = (m_pend & ~clr) | setp;
         m_shut = m_shut | sets;
         if (bus_wen) begin
            case (bus_addr)
               8'h04: begin
                  if (m_run && bus_wdata[0]) order_ok = 0;
                  m_run = bus_wdata[0]; m_src = bus_wdata[7:4]; m_pol = bus_wdata[8];
                  if (!m_run || order_ok) exp_ch = first_en(m_src);
                  gap_valid = 0;
               end
               8'h08: begin m_ien = bus_wdata[3:0]; m_gpio = bus_wdata[7:4]; m_rst = bus_wdata[11:8]; end
               8'h60: m_ideb = int'(bus_wdata[7:0]);
               8'h64: m_sdeb = int'(bus_wdata[7:0]);
               8'h68: begin m_pcool = int'(bus_wdata[15:0]); gap_valid = 0; end
               8'h6C: begin m_phot = int'(bus_wdata[15:0]); gap_valid = 0; end
               default: for (int i = 0; i < NCH; i++)
                  if (bus_addr == 8'(8'h40 + 4*i)) m_lvl[i] = int'(bus_wdata[11:0]);
            endcase
         end
      end
   end

   // converter model and per-cycle comparison at the falling edge
   always @(negedge clk) begin
      bit eg;
      if (adc_done) begin
         adc_done = 0; lat = 0;
      end else if (adc_start) begin
         lat++;
         if (lat >= LAT) begin
            adc_done = 1;
            if (alt[adc_chan]) begin
               alt_ph[adc_chan] = !alt_ph[adc_chan];
               adc_code = alt_ph[adc_chan] ? 12'h700 : 12'hC00;
            end else begin
               adc_code = 12'(code_tab[adc_chan]);
            end
         end
      end else begin
         lat = 0;
      end
      #1;
      mon_start = adc_start;
      mon_chan  = int'(adc_chan);
      if (rst_n) begin
         chk(irq == |(m_pend & m_ien), "R6 irq", irq, |(m_pend & m_ien));
         eg = (m_run && |(m_shut & m_gpio)) ? m_pol : !m_pol;
         chk(shut_gpio == eg, "R8/R9 shut_gpio", shut_gpio, eg);
         chk(shut_rst == (m_run && |(m_shut & m_rst)), "R8 shut_rst", shut_rst, m_run && |(m_shut & m_rst));
         if (!m_run) chk(!adc_start, "R10 request while idle", adc_start, 0);
         if (gap_arm) begin
            if (!mon_start) gap_cnt++;
            else begin
               if (gap_valid) chk(gap_cnt == exp_gap, "R4 sweep gap", gap_cnt, exp_gap);
               gap_arm = 0;
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wen = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wen = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      logic [31:0] e;
      @(negedge clk);
      bus_addr = a;
      #2;
      e = exp_read(a);
      chk(bus_rdata === e, tag, bus_rdata, e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      fin();
   end

   initial begin
      for (int i = 0; i < NCH; i++) code_tab[i] = 12'hC00;
      alt = 0; alt_ph = 0; lat = 0;
      idle(4);
      rst_n = 1;
      idle(2);
      // R1: reset state
      chk(irq == 0, "R1 irq", irq, 0);
      chk(shut_gpio == 1, "R1 shut_gpio", shut_gpio, 1);
      chk(shut_rst == 0, "R1 shut_rst", shut_rst, 0);
      chk(adc_start == 0, "R1 adc_start", adc_start, 0);
      rd(8'h04, "R1 control"); rd(8'h08, "R1 route"); rd(8'h0C, "R1 pending");
      rd(8'h20, "R1 data"); rd(8'h40, "R1 level"); rd(8'h68, "R1 period");

      for (int i = 0; i < NCH; i++) wr(8'(8'h40 + 4*i), 32'h800);
      wr(8'h60, 2); wr(8'h64, 3); wr(8'h68, 6); wr(8'h6C, 2);
      wr(8'h08, 32'h0000_081B);
      wr(8'h04, 32'h0000_00B1);
      idle(200);
      for (int i = 0; i < NCH; i++) rd(8'(8'h20 + 4*i), "R3 stored code");
      rd(8'h0C, "R6 nothing pending while cool");

      // boundary: one above the level, and exactly at it
      code_tab[1] = 12'h801;
      code_tab[3] = 12'h800;
      idle(300);
      rd(8'h0C, "R5 level boundary");
      rd(8'h2C, "R3 channel 3 code");

      // alternating hot/cold on channel 0 never completes a streak
      alt[0] = 1;
      idle(300);
      rd(8'h0C, "R6 broken streak");

      // clear while still hot, and try to clear the status bit
      wr(8'h0C, 32'h0000_0108);
      rd(8'h0C, "R7 clear and sticky status");
      code_tab[3] = 12'hC00;
      idle(200);
      wr(8'h0C, 32'h0000_0008);
      rd(8'h0C, "R7 cleared stays clear");

      // steady hot channel 0 reaches both limits
      alt[0] = 0;
      code_tab[0] = 12'h700;
      idle(300);
      rd(8'h0C, "R8 shutdown latched");

      // polarity flip
      wr(8'h04, 32'h0000_01B1);
      idle(20);
      rd(8'h04, "R9 polarity readback");

      // zero high-temperature period counts as one
      wr(8'h6C, 0);
      idle(300);

      // scanning off
      wr(8'h04, 32'h0000_01B0);
      idle(100);
      rd(8'h20, "R10 data held while idle");
      rd(8'h0C, "R10 pending while idle");

      // back on, then a channel set that starts above index 0
      wr(8'h04, 32'h0000_00B1);
      idle(200);
      code_tab[2] = 12'hC00;
      code_tab[0] = 12'hC00;
      code_tab[3] = 12'hC00;
      wr(8'h04, 32'h0000_00C1);
      idle(400);
      rd(8'h28, "R3 channel 2 code");
      rd(8'h0C, "R7 status after cooling");
      fin();
   end
endmodule